// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the control-port slave of a small optical front-end. A host runs frames over three lines: an enable that is high for the length of a frame, a serial clock, and one data line that the host and the slave take turns on. Each frame carries an 8-bit header and then an 8-bit data byte. The top header bit says whether the frame reads or writes. The other seven header bits give the register address. Behind the port is a small register file: one control byte and three 8-bit gain codes.

A 2-bit strap places the slave in one of three 16-address windows. Several slaves can therefore share the same wires, and only the addressed one ever drives the data line. The control byte is decoded at all times into three outputs: a power-on flag, the gain code of the selected optical bank, and a five-level amplifier gain class. The analog stages use these outputs directly.

The port lines are asynchronous to the block clock. They pass through a synchronizer, and the block detects the serial clock edges in the block clock domain. The data line is split into an input, an output and an output enable. The pad ring combines them into one bidirectional pin.

Top module: `serial_reg_slave`

## Requirements
- R1: After reset the control byte is 0x02 and all three gain codes are 0xFF. The outputs are then `pwr_on`=0, `gain_code`=0xFF and `amp_class`=4.
- R2: A frame has 16 bits and each byte is sent MSB first. Input bits are taken on rising serial clock edges while enable is high. Header bit 7 set to 1 means read and 0 means write. Header bits 3:0 give the register offset.
- R3: `win_sel` selects the window that header bits 6:4 must match: 00 selects 000 (0x00–0x0F), 01 selects 001 (0x10–0x1F), and 10 or 11 select 111 (0x70–0x7F). A write to any other window changes nothing.
- R4: A write takes effect on the 16th rising edge, and only if enable is still high at that edge. A frame cut short by enable falling changes no register, and the bit count restarts whenever enable is low.
- R5: In a read that hits the window, the data byte goes out MSB first. The first bit is launched on the falling edge after the 8th rising edge, and each later falling edge launches the next bit. `sdio_oe` stays high from that first launch until enable goes low, and it is low during the header.
- R6: A read outside the window leaves `sdio_oe` low for the whole frame.
- R7: Offsets 4 to 15 accept writes without effect and always read 0x00.
- R8: `pwr_on` is 1 only when control bits 7:6 are 11.
- R9: Control bits 3:2 select the gain code. 00 and 01 select offset 1, 10 selects offset 2, and 11 selects offset 3.
- R10: `amp_class` is decoded from control bit 1 (g2) and control bits 5:4 (g1). The codes are 0=Low, 1=Middle1, 2=Middle2, 3=High1 and 4=High2. With g2=1: g1 of 00 or 01 gives 4, and g1 of 10 or 11 gives 3. With g2=0: g1 of 00 or 01 gives 2, 10 gives 1, and 11 gives 0.
- R11: Control bit 0 is not stored and always reads 0. Bits 7:1 read back exactly as they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sen | input | 1 | Frame enable, high during a frame |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Data line as seen from the pad |
| win_sel | input | 2 | Address window strap |
| sdio_out | output | 1 | Read data toward the pad |
| sdio_oe | output | 1 | Pad drive enable for read data |
| pwr_on | output | 1 | Powered-on flag from the control byte |
| gain_code | output | 8 | Gain code of the selected bank |
| amp_class | output | 3 | Decoded amplifier gain class |

## Verification
The bench builds the block with the default two-stage synchronizer and runs the serial clock at eight block clocks per half period. This gives every serial edge time to pass through the synchronizer and the edge detector before the next one. With that spacing, read bits are sampled at the end of each low phase and inputs change with a wide margin, so the test can cover all three windows, both strap codes that select the top window, early-aborted frames, and every control field combination.

// File: rtl/srs_pkg.sv
package srs_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned OFF_W  = 4;
    localparam int unsigned TAG_W  = BYTE_W - 1 - OFF_W;

    localparam logic [BYTE_W-1:0] CTRL_RST = 8'h02;
    localparam logic [BYTE_W-1:0] GAIN_RST = 8'hFF;

    typedef struct packed {
        logic [1:0] pwr;
        logic [1:0] g1;
        logic [1:0] bank;
        logic       g2;
        logic       spare;
    } ctrl_t;

    typedef enum logic [2:0] {
        AMP_LOW   = 3'd0,
        AMP_MID1  = 3'd1,
        AMP_MID2  = 3'd2,
        AMP_HIGH1 = 3'd3,
        AMP_HIGH2 = 3'd4
    } amp_class_e;

    function automatic logic [TAG_W-1:0] window_tag(input logic [1:0] sel);
        case (sel)
            2'b00:   return 3'b000;
            2'b01:   return 3'b001;
            default: return 3'b111;
        endcase
    endfunction

    function automatic amp_class_e class_of(input ctrl_t c);
        if (c.g2)
            return c.g1[1] ? AMP_HIGH1 : AMP_HIGH2;
        case (c.g1)
            2'b10:   return AMP_MID1;
            2'b11:   return AMP_LOW;
            default: return AMP_MID2;
        endcase
    endfunction

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= '0;
                else     pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= '0;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/srs_frame.sv
module srs_frame
    import srs_pkg::*;
#(
    parameter int unsigned BW = BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sen_q,
    input  logic             sclk_q,
    input  logic             sdi_q,
    input  logic [1:0]       win_sel,
    input  logic [BW-1:0]    rd_data,
    output logic [OFF_W-1:0] reg_off,
    output logic             wr_en,
    output logic [BW-1:0]    wr_data,
    output logic             sdo,
    output logic             oe
);
    localparam int unsigned FRAME_LEN = 2 * BW;
    localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(BW - 1);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(BW);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(FRAME_LEN);

    logic             sclk_d;
    logic [CNT_W-1:0] cnt;
    logic [BW-2:0]    shreg;
    logic [BW-1:0]    txreg;
    logic [OFF_W-1:0] off_q;
    logic             is_rd, is_hit, oe_q;
    logic             rise, fall, hit_now;
    logic [BW-1:0]    byte_now;

    assign rise     = sen_q &  sclk_q & ~sclk_d;
    assign fall     = sen_q & ~sclk_q &  sclk_d;
    assign byte_now = {shreg, sdi_q};
    assign hit_now  = byte_now[BW-2:OFF_W] == window_tag(win_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
            txreg  <= '0;
            off_q  <= '0;
            is_rd  <= 1'b0;
            is_hit <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            sclk_d <= sclk_q;
            if (!sen_q) begin
                cnt    <= '0;
                is_rd  <= 1'b0;
                is_hit <= 1'b0;
                oe_q   <= 1'b0;
            end else begin
                if (rise) begin
                    shreg <= byte_now[BW-2:0];
                    if (cnt != CNT_END) cnt <= cnt + 1'b1;
                    if (cnt == CNT_HDR) begin
                        off_q  <= byte_now[OFF_W-1:0];
                        is_rd  <= byte_now[BW-1];
                        is_hit <= hit_now;
                    end
                end
                if (fall && is_rd && is_hit && cnt >= CNT_DATA && cnt < CNT_END) begin
                    oe_q  <= 1'b1;
                    txreg <= (cnt == CNT_DATA) ? rd_data : {txreg[BW-2:0], 1'b0};
                end
            end
        end
    end

    assign wr_en   = rise && (cnt == CNT_LAST) && !is_rd && is_hit;
    assign wr_data = byte_now;
    assign reg_off = off_q;
    assign sdo     = txreg[BW-1];
    assign oe      = oe_q;
endmodule

// File: rtl/srs_regfile.sv
module srs_regfile
    import srs_pkg::*;
#(
    parameter int unsigned NGAIN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              pwr_on,
    output logic [BYTE_W-1:0] gain_code,
    output amp_class_e        amp_class
);
    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] gain_q [NGAIN];

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= ctrl_t'(CTRL_RST);
        else if (wr_en && wr_off == '0)
            ctrl_q <= ctrl_t'({wr_data[BYTE_W-1:1], 1'b0});
    end

    for (genvar gi = 0; gi < NGAIN; gi++) begin : g_gain
        always_ff @(posedge clk) begin
            if (rst)
                gain_q[gi] <= GAIN_RST;
            else if (wr_en && wr_off == OFF_W'(gi + 1))
                gain_q[gi] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (wr_off == '0) rd_data = ctrl_q;
        for (int i = 0; i < NGAIN; i++)
            if (wr_off == OFF_W'(i + 1)) rd_data = gain_q[i];
    end

    always_comb begin
        case (ctrl_q.bank)
            2'b10:   gain_code = gain_q[1];
            2'b11:   gain_code = gain_q[2];
            default: gain_code = gain_q[0];
        endcase
    end

    assign pwr_on    = ctrl_q.pwr == 2'b11;
    assign amp_class = class_of(ctrl_q);
endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
    import srs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sen,
    input  logic       sclk,
    input  logic       sdio_in,
    input  logic [1:0] win_sel,
    output logic       sdio_out,
    output logic       sdio_oe,
    output logic       pwr_on,
    output logic [7:0] gain_code,
    output logic [2:0] amp_class
);
    logic              sen_q, sclk_q, sdi_q;
    logic [OFF_W-1:0]  reg_off;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data, rd_data;
    amp_class_e        cls;

    srs_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sen, sclk, sdio_in}),
        .q   ({sen_q, sclk_q, sdi_q})
    );

    srs_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .sen_q   (sen_q),
        .sclk_q  (sclk_q),
        .sdi_q   (sdi_q),
        .win_sel (win_sel),
        .rd_data (rd_data),
        .reg_off (reg_off),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sdo     (sdio_out),
        .oe      (sdio_oe)
    );

    srs_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_off    (reg_off),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .pwr_on    (pwr_on),
        .gain_code (gain_code),
        .amp_class (cls)
    );

    assign amp_class = cls;
endmodule

// File: rtl/srs_chk.sv
module srs_chk (
    input logic       clk,
    input logic       rst,
    input logic       sen_q,
    input logic       wr_en,
    input logic       sdio_oe,
    input logic       pwr_on,
    input logic [7:0] gain_code,
    input logic [2:0] amp_class
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pwr_on && gain_code == 8'hFF && amp_class == 3'd4)); // R1

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(pwr_on) && $stable(gain_code) && $stable(amp_class))); // R4

    AST_DRIVE_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        !sen_q |=> !sdio_oe); // R5

    AST_NO_WRITE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (rst)
        sdio_oe |-> !wr_en); // R2
endmodule

bind serial_reg_slave srs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sen_q     (sen_q),
    .wr_en     (wr_en),
    .sdio_oe   (sdio_oe),
    .pwr_on    (pwr_on),
    .gain_code (gain_code),
    .amp_class (amp_class)
);

// File: tb/sim_serial_reg_slave.sv
`timescale 1ns/1ps
module sim_serial_reg_slave;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sen = 1'b0, sclk = 1'b0, sdio_in = 1'b0;
    logic [1:0] win_sel = 2'b00;
    logic       sdio_out, sdio_oe, pwr_on;
    logic [7:0] gain_code;
    logic [2:0] amp_class;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_ctrl;
    logic [7:0] m_g [3];

    always #5 clk = ~clk;

    serial_reg_slave u0 (
        .clk(clk), .rst(rst), .sen(sen), .sclk(sclk), .sdio_in(sdio_in),
        .win_sel(win_sel), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .pwr_on(pwr_on), .gain_code(gain_code), .amp_class(amp_class)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] tag_of(input logic [1:0] s);
        return (s == 2'b00) ? 3'b000 : (s == 2'b01) ? 3'b001 : 3'b111;
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] off);
        if (off == 4'd0) return m_ctrl;
        if (off >= 4'd1 && off <= 4'd3) return m_g[off - 1];
        return 8'h00;
    endfunction

    function automatic logic [2:0] exp_class(input logic [7:0] c);
        if (c[1]) return c[5] ? 3'd3 : 3'd4;
        case (c[5:4])
            2'b10:   return 3'd1;
            2'b11:   return 3'd0;
            default: return 3'd2;
        endcase
    endfunction

    function automatic logic [7:0] exp_gain(input logic [7:0] c);
        case (c[3:2])
            2'b10:   return m_g[1];
            2'b11:   return m_g[2];
            default: return m_g[0];
        endcase
    endfunction

    task automatic check_outs();
        check("R8 pwr_on", {31'd0, pwr_on}, {31'd0, m_ctrl[7:6] == 2'b11});
        check("R9 gain_code", {24'd0, gain_code}, {24'd0, exp_gain(m_ctrl)});
        check("R10 amp_class", {29'd0, amp_class}, {29'd0, exp_class(m_ctrl)});
    endtask

    // runs nbits slots of a frame; checks read data and drive enable
    task automatic frame(input logic [7:0] a, input logic [7:0] d, input int nbits);
        logic [7:0]  got = 8'h00;
        logic [15:0] oev = 16'h0000;
        logic        hit = (a[6:4] == tag_of(win_sel));
        sen = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            sclk    = 1'b0;
            sdio_in = (i < 8) ? a[7 - i] : d[15 - i];
            repeat (HALF) @(negedge clk);
            oev[i] = sdio_oe;
            if (i >= 8) got[15 - i] = sdio_out;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        sen = 1'b0;
        repeat (2 * HALF) @(negedge clk);
        if (a[7] && nbits == 16) begin
            if (hit) begin
                check("R5 read data", {24'd0, got}, {24'd0, exp_read(a[3:0])});
                check("R5 drive enable", {16'd0, oev}, 32'h0000_FF00);
            end else begin
                check("R6 foreign read silent", {16'd0, oev}, 32'h0);
            end
        end else if (!a[7] && hit && nbits == 16) begin
            if (a[3:0] == 4'd0) m_ctrl = d & 8'hFE;
            else if (a[3:0] <= 4'd3) m_g[a[3:0] - 1] = d;
        end
        check("R5 released after frame", {31'd0, sdio_oe}, 32'h0);
        check_outs();
    endtask

    task automatic rd_expect(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] got = 8'h00;
        sen = 1'b1;
        for (int i = 0; i < 16; i++) begin
            sclk    = 1'b0;
            sdio_in = (i < 8) ? a[7 - i] : 1'b1;
            repeat (HALF) @(negedge clk);
            if (i >= 8) got[15 - i] = sdio_out;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        sen = 1'b0;
        repeat (2 * HALF) @(negedge clk);
        check(req, {24'd0, got}, {24'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] base [4];
        void'($urandom(32'h5EED_0A11));
        m_ctrl = 8'h02;
        for (int k = 0; k < 3; k++) m_g[k] = 8'hFF;
        base[0] = 8'h00; base[1] = 8'h10; base[2] = 8'h70; base[3] = 8'h70;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset state
        check("R1 pwr_on", {31'd0, pwr_on}, 32'd0);
        check("R1 gain_code", {24'd0, gain_code}, 32'hFF);
        check("R1 amp_class", {29'd0, amp_class}, 32'd4);
        rd_expect("R1 ctrl reset", 8'h80, 8'h02);
        rd_expect("R1 gain3 reset", 8'h83, 8'hFF);

        // R11 bit 0 dropped, R2 header decode
        frame(8'h00, 8'hC9, 16);
        rd_expect("R11 ctrl readback", 8'h80, 8'hC8);
        frame(8'h02, 8'h5A, 16);
        rd_expect("R2 gain2 readback", 8'h82, 8'h5A);

        // R3 foreign window write ignored
        frame(8'h11, 8'h33, 16);
        rd_expect("R3 foreign write ignored", 8'h81, 8'hFF);

        // R4 aborted frames
        frame(8'h02, 8'h12, 12);
        rd_expect("R4 abort keeps value", 8'h82, 8'h5A);
        frame(8'h00, 8'hFF, 15);
        rd_expect("R4 abort at 15 bits", 8'h80, 8'hC8);

        // R7 unused and test offsets
        frame(8'h04, 8'hAA, 16);
        rd_expect("R7 offset 4 reads zero", 8'h84, 8'h00);
        frame(8'h0E, 8'h55, 16);
        rd_expect("R7 offset E reads zero", 8'h8E, 8'h00);
        rd_expect("R7 offset F reads zero", 8'h8F, 8'h00);

        // R6 foreign read
        frame(8'hF0, 8'h00, 16);

        // R3 other windows
        win_sel = 2'b01;
        frame(8'h13, 8'h3C, 16);
        rd_expect("R3 window 1 write", 8'h93, 8'h3C);
        win_sel = 2'b10;
        frame(8'h71, 8'hA5, 16);
        rd_expect("R3 window 7 write", 8'hF1, 8'hA5);
        win_sel = 2'b11;
        rd_expect("R3 strap 11 window 7", 8'hF1, 8'hA5);
        frame(8'h81, 8'h00, 16);

        // R8 R9 R10 every control field combination
        for (int c = 0; c < 128; c += 1) begin
            frame(8'h70, 8'((c << 1) | (c & 1)), 16);
        end

        // random mix
        for (int n = 0; n < 150; n++) begin
            logic [7:0] a;
            if ($urandom_range(0, 7) == 0) win_sel = 2'($urandom_range(0, 3));
            a = base[$urandom_range(0, 3)] | 8'($urandom_range(0, 15));
            if ($urandom_range(0, 4) < 2) a[7] = 1'b1;
            frame(a, 8'($urandom_range(0, 255)), ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, 15)) : 16);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule